// File: doc/BRIEF.md
# Timing Output Power-Up Sequencer

This block brings the digital side of a CCD timing generator out of power-up in an orderly way. After the supply-settled indication (`rst`) drops, it holds an internal active-low power-on reset for a programmable number of master-clock cycles. It then accepts 32-bit writes over a three-wire serial port. Three addresses are decoded: a software-reset word, a standby word with separate digital and analog bits, and an output-control word. While the output enable is clear, every timing output sits at a fixed safe level. Some outputs are held high and others low. The live timing from the external waveform generator reaches the pins only a fixed number of master-clock cycles after the enable rises.

The serial lines are oversampled by the master clock through a three-stage synchroniser, so the enable moves on a predictable master-clock edge after the 32nd serial clock. A clock-ready flag models the settling time of the derived pixel clock after the digital circuits leave standby. A three-bit status code shows the sequencer's phase.

Top module: `pwrup_out_seq`

## Requirements
- R1: After `rst` falls, `por_n` stays low for exactly POR_CYCLES master-clock edges and then stays high until `rst` rises again. While `por_n` is low, status is 0, the outputs are at safe levels and any serial frame has no effect.
- R2: A frame is framed by `sl_n` low and carries 32 bits on SCK rising edges, MSB first: an 8-bit address, then 24 data bits. SCK high and low phases each last at least two master-clock periods.
- R3: A frame in which `sl_n` rises before the 32nd SCK rising edge is discarded and changes no register.
- R4: Writing data 0 to address 0x00 returns every register to its default (enable off, both standby bits 0). Nonzero data to 0x00, and any address other than 0x00, 0x01 or 0x02, changes nothing.
- R5: At address 0x02, bit 0 is the digital-on bit and bit 1 is the analog-on bit, both defaulting to 0. While outputs are not live and either bit is 0, status is 1 (standby).
- R6: `clk_ready` rises exactly SETTLE_CYCLES master-clock edges after the digital-on bit is set, and it clears when that bit clears. With both standby bits at 1 and `clk_ready` low, status is 2 (settling). With `clk_ready` high and outputs not live, status is 3.
- R7: At address 0x01, bit 0 is the output enable. It commits on the third master-clock edge after the master clock first samples the 32nd SCK rising edge high.
- R8: The outputs carry the live inputs starting exactly four master-clock edges after the enable rises, which is the seventh edge after the 32nd SCK rise. Status is then 4, whatever the standby bits are.
- R9: While outputs are not live, all six `v_out` bits, all four `tg_out` bits, `ofd_out` and all four `h1_out` bits are 1, and both `h2_out` bits, `lm_out` and `rs_out` are 0.
- R10: A write that clears the enable forces the safe levels from the same master-clock edge that commits it, which is the third edge after the 32nd SCK rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset, high while the supply is not settled |
| sck | input | 1 | Serial clock |
| sdata | input | 1 | Serial data, MSB first |
| sl_n | input | 1 | Active-low frame strobe |
| v_in | input | 6 | Live vertical phases |
| tg_in | input | 4 | Live transfer gates |
| ofd_in | input | 1 | Live overflow drain |
| h1_in | input | 4 | Live first horizontal phases |
| h2_in | input | 2 | Live second horizontal phases |
| lm_in | input | 1 | Live line marker |
| rs_in | input | 1 | Live reset gate |
| v_out | output | 6 | Vertical phases, safe high |
| tg_out | output | 4 | Transfer gates, safe high |
| ofd_out | output | 1 | Overflow drain, safe high |
| h1_out | output | 4 | First horizontal phases, safe high |
| h2_out | output | 2 | Second horizontal phases, safe low |
| lm_out | output | 1 | Line marker, safe low |
| rs_out | output | 1 | Reset gate, safe low |
| por_n | output | 1 | Internal power-on reset, active low |
| clk_ready | output | 1 | Derived pixel clock settled |
| status | output | 3 | 0 reset, 1 standby, 2 settling, 3 ready with outputs off, 4 outputs live |

## Verification
The assertions check on every cycle that `por_n` never falls again once it is high, and that the outputs sit at their safe levels whenever the enable is low or the power-on reset is active. They also check that live outputs always have the enable behind them for the last four cycles, that a fresh enable never makes the outputs live on the next edge, and that a new digital-on bit does not raise `clk_ready` at once. The exact edge counts need the bench's directed scenarios: the seventh-edge release, the third-edge shutdown and the settle time. The same holds for writes ignored during the power-on reset, aborted frames and the software-reset word, each checked at the ports against a bench model of the three registers.

// File: rtl/pos_pkg.sv
package pos_pkg;

    localparam int V_W   = 6;
    localparam int TG_W  = 4;
    localparam int H1_W  = 4;
    localparam int H2_W  = 2;

    localparam int FRAME_W = 32;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = FRAME_W - ADDR_W;

    localparam int RELEASE_LAT = 4;

    localparam logic [ADDR_W-1:0] A_SWRST  = 8'h00;
    localparam logic [ADDR_W-1:0] A_OUTCTL = 8'h01;
    localparam logic [ADDR_W-1:0] A_STBY   = 8'h02;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_STANDBY = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_OFF     = 3'd3,
        ST_LIVE    = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic [V_W-1:0]  v;
        logic [TG_W-1:0] tg;
        logic            ofd;
        logic [H1_W-1:0] h1;
        logic [H2_W-1:0] h2;
        logic            lm;
        logic            rs;
    } timing_t;

    typedef struct packed {
        logic              stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    function automatic timing_t safe_levels();
        timing_t t;
        t.v   = '1;
        t.tg  = '1;
        t.ofd = 1'b1;
        t.h1  = '1;
        t.h2  = '0;
        t.lm  = 1'b0;
        t.rs  = 1'b0;
        return t;
    endfunction

endpackage

// File: rtl/pos_por.sv
module pos_por #(
    parameter int POR_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic por_n
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(POR_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign por_n = (cnt == LAST);

    AST_POR_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
        por_n |=> por_n); // R1

endmodule

// File: rtl/pos_serial.sv
module pos_serial
    import pos_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck,
    input  logic    sdata,
    input  logic    sl_n,
    output wr_cmd_t cmd
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic [2:0]           sck_s;
    logic [1:0]           sd_s;
    logic [1:0]           sl_s;
    logic [FRAME_W-2:0]   shreg;
    logic [CNT_W-1:0]     bit_cnt;
    logic                 rise;
    logic [FRAME_W-1:0]   word;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s <= '0;
            sd_s  <= '0;
            sl_s  <= '1;
        end else begin
            sck_s <= {sck_s[1:0], sck};
            sd_s  <= {sd_s[0], sdata};
            sl_s  <= {sl_s[0], sl_n};
        end
    end

    assign rise = sck_s[1] & ~sck_s[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (sl_s[1]) begin
            bit_cnt <= '0;
        end else if (rise) begin
            shreg   <= {shreg[FRAME_W-3:0], sd_s[1]};
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    assign word     = {shreg, sd_s[1]};
    assign cmd.stb  = rise & ~sl_s[1] & (bit_cnt == LAST_BIT);
    assign cmd.addr = word[FRAME_W-1 -: ADDR_W];
    assign cmd.data = word[DATA_W-1:0];

    AST_ONE_STROBE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
        cmd.stb |=> !cmd.stb && bit_cnt == '0); // R2

endmodule

// File: rtl/pos_regs.sv
module pos_regs
    import pos_pkg::*;
#(
    parameter int SETTLE_CYCLES = 25000
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    output logic    oe,
    output logic    dig_on,
    output logic    afe_on,
    output logic    clk_ready
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES);

    logic [SW-1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe     <= 1'b0;
            dig_on <= 1'b0;
            afe_on <= 1'b0;
        end else if (cmd.stb) begin
            case (cmd.addr)
                A_SWRST: begin
                    if (cmd.data == '0) begin
                        oe     <= 1'b0;
                        dig_on <= 1'b0;
                        afe_on <= 1'b0;
                    end
                end
                A_OUTCTL: oe <= cmd.data[0];
                A_STBY: begin
                    dig_on <= cmd.data[0];
                    afe_on <= cmd.data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !dig_on)
            settle_cnt <= '0;
        else if (settle_cnt != SETTLE_LAST)
            settle_cnt <= settle_cnt + 1'b1;
    end

    assign clk_ready = dig_on && (settle_cnt == SETTLE_LAST);

    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd.stb && cmd.addr == A_SWRST && cmd.data == '0) |=> (!oe && !dig_on && !afe_on)); // R4
    AST_READY_WAITS: assert property (@(posedge clk) disable iff (rst)
        $rose(dig_on) |-> !clk_ready); // R6

endmodule

// File: rtl/pos_release.sv
module pos_release
    import pos_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    oe,
    input  timing_t live_in,
    output timing_t pins,
    output logic    live
);
    localparam int LW = $clog2(RELEASE_LAT + 1);
    localparam logic [LW-1:0] LAT = LW'(RELEASE_LAT);

    logic [LW-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst || !oe)
            lat_cnt <= '0;
        else if (lat_cnt != LAT)
            lat_cnt <= lat_cnt + 1'b1;
    end

    assign live = oe && (lat_cnt == LAT);
    assign pins = live ? live_in : safe_levels();

    AST_OFF_IS_SAFE: assert property (@(posedge clk) disable iff (rst)
        !oe |-> pins == safe_levels()); // R10
    AST_NOT_LIVE_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |=> !live); // R8

endmodule

// File: rtl/pwrup_out_seq.sv
module pwrup_out_seq
    import pos_pkg::*;
#(
    parameter int POR_CYCLES    = 50000,
    parameter int SETTLE_CYCLES = 25000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck,
    input  logic             sdata,
    input  logic             sl_n,
    input  logic [V_W-1:0]   v_in,
    input  logic [TG_W-1:0]  tg_in,
    input  logic             ofd_in,
    input  logic [H1_W-1:0]  h1_in,
    input  logic [H2_W-1:0]  h2_in,
    input  logic             lm_in,
    input  logic             rs_in,
    output logic [V_W-1:0]   v_out,
    output logic [TG_W-1:0]  tg_out,
    output logic             ofd_out,
    output logic [H1_W-1:0]  h1_out,
    output logic [H2_W-1:0]  h2_out,
    output logic             lm_out,
    output logic             rs_out,
    output logic             por_n,
    output logic             clk_ready,
    output logic [2:0]       status
);
    logic       core_rst;
    wr_cmd_t    cmd;
    logic       oe, dig_on, afe_on, live;
    timing_t    live_in, pins;
    seq_state_e state;

    pos_por #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk   (clk),
        .rst   (rst),
        .por_n (por_n)
    );

    assign core_rst = rst | ~por_n;

    pos_serial u_serial (
        .clk   (clk),
        .rst   (core_rst),
        .sck   (sck),
        .sdata (sdata),
        .sl_n  (sl_n),
        .cmd   (cmd)
    );

    pos_regs #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_regs (
        .clk       (clk),
        .rst       (core_rst),
        .cmd       (cmd),
        .oe        (oe),
        .dig_on    (dig_on),
        .afe_on    (afe_on),
        .clk_ready (clk_ready)
    );

    assign live_in = '{v: v_in, tg: tg_in, ofd: ofd_in, h1: h1_in,
                       h2: h2_in, lm: lm_in, rs: rs_in};

    pos_release u_rel (
        .clk     (clk),
        .rst     (core_rst),
        .oe      (oe),
        .live_in (live_in),
        .pins    (pins),
        .live    (live)
    );

    assign v_out   = pins.v;
    assign tg_out  = pins.tg;
    assign ofd_out = pins.ofd;
    assign h1_out  = pins.h1;
    assign h2_out  = pins.h2;
    assign lm_out  = pins.lm;
    assign rs_out  = pins.rs;

    always_comb begin
        if (!por_n)                 state = ST_RESET;
        else if (live)              state = ST_LIVE;
        else if (!dig_on || !afe_on) state = ST_STANDBY;
        else if (!clk_ready)        state = ST_SETTLE;
        else                        state = ST_OFF;
    end

    assign status = state;

    AST_POR_SAFE: assert property (@(posedge clk) disable iff (rst)
        !por_n |-> (v_out == '1 && tg_out == '1 && ofd_out && h1_out == '1
                    && h2_out == '0 && !lm_out && !rs_out)); // R9
    AST_LIVE_AFTER_FOUR: assert property (@(posedge clk) disable iff (rst)
        live |-> $past(oe, 4)); // R8

endmodule

// File: tb/tb_pwrup_out_seq.sv
module tb_pwrup_out_seq;

    localparam int POR    = 300;
    localparam int SETTLE = 30;
    localparam logic [18:0] SAFE = 19'b111111111111111_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, sdata = 1'b0, sl_n = 1'b1;
    logic [5:0] v_in = '0;
    logic [3:0] tg_in = '0, h1_in = '0;
    logic ofd_in = 1'b0, lm_in = 1'b0, rs_in = 1'b0;
    logic [1:0] h2_in = '0;
    logic [5:0] v_out;
    logic [3:0] tg_out, h1_out;
    logic ofd_out, lm_out, rs_out, por_n, clk_ready;
    logic [1:0] h2_out;
    logic [2:0] status;

    int checks = 0, errors = 0, cyc = 0;
    logic m_oe = 0, m_dig = 0, m_afe = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    pwrup_out_seq #(.POR_CYCLES(POR), .SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst(rst), .sck(sck), .sdata(sdata), .sl_n(sl_n),
        .v_in(v_in), .tg_in(tg_in), .ofd_in(ofd_in), .h1_in(h1_in),
        .h2_in(h2_in), .lm_in(lm_in), .rs_in(rs_in),
        .v_out(v_out), .tg_out(tg_out), .ofd_out(ofd_out), .h1_out(h1_out),
        .h2_out(h2_out), .lm_out(lm_out), .rs_out(rs_out),
        .por_n(por_n), .clk_ready(clk_ready), .status(status));

    function automatic logic [18:0] exp_pins(logic live_now);
        return live_now ? {v_in, tg_in, ofd_in, h1_in, h2_in, lm_in, rs_in} : SAFE;
    endfunction

    function automatic logic [2:0] exp_status(logic oe, logic dig, logic afe, logic rdy);
        if (oe) return 3'd4;
        if (!dig || !afe) return 3'd1;
        if (!rdy) return 3'd2;
        return 3'd3;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shake();
        {v_in, tg_in, ofd_in, h1_in, h2_in, lm_in, rs_in} = 19'($urandom);
        #1;
    endtask

    task automatic check_pins(string req, logic live_now);
        shake();
        check(req, 32'({v_out, tg_out, ofd_out, h1_out, h2_out, lm_out, rs_out}),
              32'(exp_pins(live_now)));
    endtask

    // mode 0 plain, 1 enable-latency, 2 disable-latency, 3 settle timing
    task automatic send_frame(logic [7:0] addr, logic [23:0] data, int nbits, int mode);
        logic [31:0] w = {addr, data};
        @(negedge clk); sl_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdata = w[31-i]; sck = 1'b0;
            repeat (2) @(negedge clk);
            sck = 1'b1;
            if (i == 31 && mode == 1) begin
                repeat (6) @(negedge clk);
                check_pins("R8 still safe after six edges", 1'b0);
                @(negedge clk);
                check_pins("R8 live at seventh edge", 1'b1);
                check("R8 status live", 32'(status), 32'd4);
            end else if (i == 31 && mode == 2) begin
                repeat (2) @(negedge clk);
                check_pins("R10 live before commit edge", 1'b1);
                @(negedge clk);
                check_pins("R10 safe at commit edge", 1'b0);
            end else if (i == 31 && mode == 3) begin
                repeat (SETTLE + 2) @(negedge clk);
                check("R6 not ready one edge early", 32'(clk_ready), 32'd0);
                check("R6 status settling", 32'(status), 32'd2);
                @(negedge clk);
                check("R6 ready on time", 32'(clk_ready), 32'd1);
                check("R6 status ready", 32'(status), 32'd3);
            end else begin
                repeat (2) @(negedge clk);
            end
        end
        sck = 1'b0;
        repeat (2) @(negedge clk);
        sl_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic settle_and_check(string tag);
        repeat (SETTLE + 12) @(negedge clk);
        check({tag, " status"}, 32'(status), 32'(exp_status(m_oe, m_dig, m_afe, m_dig)));
        check({tag, " clk_ready"}, 32'(clk_ready), 32'(m_dig));
        check_pins({tag, " pins"}, m_oe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        check("R1 por_n low in reset", 32'(por_n), 32'd0);
        check_pins("R9 safe in reset", 1'b0);
        rst = 1'b0;
        // R1: a write during the power-on reset has no effect
        send_frame(8'h01, 24'h000001, 32, 0);
        send_frame(8'h02, 24'h000003, 32, 0);
        while (cyc < POR - 1) @(negedge clk);
        check("R1 por_n low one edge before end", 32'(por_n), 32'd0);
        check("R1 status reset", 32'(status), 32'd0);
        @(negedge clk);
        check("R1 por_n high at end", 32'(por_n), 32'd1);
        settle_and_check("R1 writes in reset ignored");

        // R5 standby combinations
        send_frame(8'h02, 24'h000002, 32, 0); m_afe = 1; m_dig = 0;
        settle_and_check("R5 analog only");
        send_frame(8'h02, 24'h000000, 32, 0); m_afe = 0;
        // R6 settle timing
        send_frame(8'h02, 24'h000003, 32, 3); m_dig = 1; m_afe = 1;
        settle_and_check("R6 settled");

        // R3 aborted enable frame
        send_frame(8'h01, 24'h000001, 20, 0);
        settle_and_check("R3 aborted frame");
        send_frame(8'h01, 24'h000001, 31, 0);
        settle_and_check("R3 frame short by one");

        // R7 R8 enable latency
        send_frame(8'h01, 24'h000001, 32, 1); m_oe = 1;
        settle_and_check("R7 enabled");
        // R4 nonzero data to 0x00 ignored, unknown address ignored
        send_frame(8'h00, 24'h000100, 32, 0);
        settle_and_check("R4 nonzero swreset ignored");
        send_frame(8'h03, 24'h000000, 32, 0);
        settle_and_check("R4 unknown address ignored");
        // R10 disable latency
        send_frame(8'h01, 24'h000000, 32, 2); m_oe = 0;
        settle_and_check("R10 disabled");
        // R4 soft reset
        send_frame(8'h01, 24'h000001, 32, 0); m_oe = 1;
        send_frame(8'h00, 24'h000000, 32, 0); m_oe = 0; m_dig = 0; m_afe = 0;
        settle_and_check("R4 soft reset");

        // random mix
        for (int n = 0; n < 40; n++) begin
            logic [7:0]  a;
            logic [23:0] d;
            int nb;
            int sel = int'($urandom_range(0, 4));
            a = (sel == 4) ? 8'(3 + $urandom_range(0, 250)) : 8'(sel % 3);
            d = 24'($urandom);
            if (a == 8'h00 && $urandom_range(0, 1) == 1) d = '0;
            nb = ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 31)) : 32;
            send_frame(a, d, nb, 0);
            if (nb == 32) begin
                case (a)
                    8'h00: if (d == '0) begin m_oe = 0; m_dig = 0; m_afe = 0; end
                    8'h01: m_oe = d[0];
                    8'h02: begin m_dig = d[0]; m_afe = d[1]; end
                    default: ;
                endcase
            end
            settle_and_check("R2 random frame");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule